// File: doc/BRIEF.md
# Line BIP-8 error counter

This block sits behind the framer and descrambler of an STS-1 receiver. It takes the descrambled byte stream together with a start-of-frame marker, a loss-of-frame flag and the row and column of each byte. It builds an even bit-interleaved parity over each frame, leaving out the nine section overhead bytes. It then checks that parity against the line parity byte carried in the next frame, at row 5, column 1.

Mismatches go into a running counter. The counter adds either the number of differing parity bits or one per errored frame, depending on a mode input. A one-cycle performance-monitor strobe copies the running count into a holding register and restarts the count. A configuration input chooses whether the counter sticks at its maximum value or wraps when it overflows. The counter width is a parameter and defaults to the 18 bits of the holding register.

Top module: `line_bip8_counter`

## Requirements
- R1: The parity is the even bitwise XOR of every valid byte in a frame, except the bytes in rows 1 to 3, columns 1 to 3. Rows and columns are numbered from 1, and each frame starts with the byte that carries the start-of-frame marker.
- R2: The parity of frame N is compared with the byte at row 5, column 1 of frame N+1. That byte is also part of the parity of frame N+1.
- R3: With cfg_block_mode = 0, each comparison adds the number of differing bits (0 to 8) to the running count.
- R4: With cfg_block_mode = 1, each comparison adds 1 if any bit differs and 0 otherwise.
- R5: A cycle with pm_strobe = 1 loads hold_count with the running count as it stood before that clock edge. In every other cycle, hold_count keeps its value.
- R6: A strobe restarts the running count from zero. An error amount applied in the same cycle as the strobe becomes the first value of the new interval and is not lost.
- R7: With cfg_saturate = 1, an addition that would pass 2^CNT_W - 1 leaves the count at 2^CNT_W - 1 until the next strobe.
- R8: With cfg_saturate = 0, the count wraps modulo 2^CNT_W.
- R9: No comparison is made in the first frame after reset, or in the first frame after in_lof has been high, because no full previous-frame parity exists.
- R10: After reset, hold_count and the running count are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_block_mode | input | 1 | 1 = count errored frames, 0 = count errored bits |
| cfg_saturate | input | 1 | 1 = saturate on overflow, 0 = wrap |
| in_valid | input | 1 | The byte on in_data is valid |
| in_sof | input | 1 | The byte is row 1, column 1 of a frame |
| in_lof | input | 1 | The framer is out of frame |
| in_row | input | 4 | Row of the byte, 1 to 9 |
| in_col | input | 7 | Column of the byte, 1 to 90 |
| in_data | input | 8 | Descrambled byte |
| pm_strobe | input | 1 | Performance-monitor transfer strobe |
| hold_count | output | CNT_W (18) | Count captured by the last strobe |

## Verification
Two events can land in the same cycle: a strobe, and the error amount that the comparison stage hands to the counter. The bench provokes this by raising the strobe on the byte right after the row 5, column 1 byte, so the strobe reaches the counter at the same edge as that frame's error amount. The check has two parts. The hold value must contain only the errors from earlier frames. The next strobe must then return exactly the bits injected into the frame where the two events met.

// File: rtl/bip_pkg.sv
package bip_pkg;

   // Error amount handed from the comparison stage to the counter
   typedef struct packed {
      logic       vld;
      logic [3:0] amt;
   } err_inc_t;

   function automatic logic [3:0] ones8(input logic [7:0] v);
      logic [3:0] n;
      n = '0;
      for (int i = 0; i < 8; i++) n = n + {3'b000, v[i]};
      return n;
   endfunction

endpackage

// File: rtl/bip_accum.sv
module bip_accum #(
   parameter int ROWS     = 9,
   parameter int COLS     = 90,
   parameter int SOH_ROWS = 3,
   parameter int SOH_COLS = 3,
   parameter int CHK_ROW  = 5,
   parameter int CHK_COL  = 1,
   localparam int ROW_W   = $clog2(ROWS + 1),
   localparam int COL_W   = $clog2(COLS + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic             in_sof,
   input  logic             in_lof,
   input  logic [ROW_W-1:0] in_row,
   input  logic [COL_W-1:0] in_col,
   input  logic [7:0]       in_data,
   output logic             chk_hit,
   output logic [7:0]       chk_byte,
   output logic [7:0]       ref_par
);
   localparam logic [ROW_W-1:0] SOH_R = ROW_W'(SOH_ROWS);
   localparam logic [COL_W-1:0] SOH_C = COL_W'(SOH_COLS);
   localparam logic [ROW_W-1:0] CHK_R = ROW_W'(CHK_ROW);
   localparam logic [COL_W-1:0] CHK_C = COL_W'(CHK_COL);

   logic [7:0] acc;
   logic       acc_full;   // accumulation began at a frame start
   logic       ref_ok;     // ref_par holds a complete frame
   logic       in_soh;

   assign in_soh = (in_row != '0) && (in_row <= SOH_R) &&
                   (in_col != '0) && (in_col <= SOH_C);

   always_ff @(posedge clk) begin
      if (!rst_n || in_lof) begin
         acc      <= '0;
         acc_full <= 1'b0;
         ref_ok   <= 1'b0;
         ref_par  <= '0;
      end else if (in_valid) begin
         if (in_sof) begin
            ref_par  <= acc;
            ref_ok   <= acc_full;
            acc_full <= 1'b1;
            acc      <= in_soh ? 8'h00 : in_data;
         end else if (!in_soh) begin
            acc <= acc ^ in_data;
         end
      end
   end

   assign chk_hit  = in_valid && !in_lof && ref_ok && !in_sof &&
                     (in_row == CHK_R) && (in_col == CHK_C);
   assign chk_byte = in_data;
endmodule

// File: rtl/bip_compare.sv
module bip_compare
   import bip_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cfg_block_mode,
   input  logic       chk_hit,
   input  logic [7:0] chk_byte,
   input  logic [7:0] ref_par,
   output err_inc_t   inc
);
   logic [7:0] diff;

   for (genvar b = 0; b < 8; b++) begin : g_lane
      assign diff[b] = chk_byte[b] ^ ref_par[b];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         inc <= '0;
      end else begin
         inc.vld <= chk_hit;
         inc.amt <= cfg_block_mode ? {3'b000, |diff} : ones8(diff);
      end
   end
endmodule

// File: rtl/bip_err_counter.sv
module bip_err_counter
   import bip_pkg::*;
#(
   parameter int CNT_W = 18
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_saturate,
   input  logic             pm_strobe,
   input  err_inc_t         inc,
   output logic [CNT_W-1:0] run_count,
   output logic [CNT_W-1:0] hold_count
);
   localparam logic [CNT_W-1:0] MAXV = '1;

   if (CNT_W < 4) begin : g_bad_width
      $error("bip_err_counter: CNT_W must be at least 4");
   end

   logic [CNT_W:0]   sum;
   logic [CNT_W-1:0] nxt;

   assign sum = {1'b0, run_count} + {{(CNT_W-3){1'b0}}, inc.amt};
   assign nxt = sum[CNT_W] ? (cfg_saturate ? MAXV : sum[CNT_W-1:0])
                           : sum[CNT_W-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_count  <= '0;
         hold_count <= '0;
      end else if (pm_strobe) begin
         hold_count <= run_count;
         run_count  <= inc.vld ? {{(CNT_W-4){1'b0}}, inc.amt} : '0;
      end else if (inc.vld) begin
         run_count <= nxt;
      end
   end
endmodule

// File: rtl/line_bip8_counter.sv
module line_bip8_counter
   import bip_pkg::*;
#(
   parameter int CNT_W    = 18,
   parameter int ROWS     = 9,
   parameter int COLS     = 90,
   parameter int SOH_ROWS = 3,
   parameter int SOH_COLS = 3,
   parameter int CHK_ROW  = 5,
   parameter int CHK_COL  = 1,
   localparam int ROW_W   = $clog2(ROWS + 1),
   localparam int COL_W   = $clog2(COLS + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_block_mode,
   input  logic             cfg_saturate,
   input  logic             in_valid,
   input  logic             in_sof,
   input  logic             in_lof,
   input  logic [ROW_W-1:0] in_row,
   input  logic [COL_W-1:0] in_col,
   input  logic [7:0]       in_data,
   input  logic             pm_strobe,
   output logic [CNT_W-1:0] hold_count
);
   if (CHK_ROW <= SOH_ROWS || CHK_ROW > ROWS || CHK_COL > COLS) begin : g_bad_pos
      $error("line_bip8_counter: check byte position outside line overhead");
   end

   logic             chk_hit;
   logic [7:0]       chk_byte;
   logic [7:0]       ref_par;
   err_inc_t         inc;
   logic             inc_vld;
   logic [3:0]       inc_amt;
   logic [CNT_W-1:0] run_count;

   bip_accum #(
      .ROWS(ROWS), .COLS(COLS), .SOH_ROWS(SOH_ROWS), .SOH_COLS(SOH_COLS),
      .CHK_ROW(CHK_ROW), .CHK_COL(CHK_COL)
   ) u_accum (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
      .in_lof(in_lof), .in_row(in_row), .in_col(in_col), .in_data(in_data),
      .chk_hit(chk_hit), .chk_byte(chk_byte), .ref_par(ref_par)
   );

   bip_compare u_cmp (
      .clk(clk), .rst_n(rst_n), .cfg_block_mode(cfg_block_mode),
      .chk_hit(chk_hit), .chk_byte(chk_byte), .ref_par(ref_par), .inc(inc)
   );

   assign inc_vld = inc.vld;
   assign inc_amt = inc.amt;

   bip_err_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .cfg_saturate(cfg_saturate),
      .pm_strobe(pm_strobe), .inc(inc), .run_count(run_count),
      .hold_count(hold_count)
   );
endmodule

// File: rtl/line_bip8_checker.sv
module line_bip8_checker #(
   parameter int CNT_W = 18
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cfg_block_mode,
   input logic             cfg_saturate,
   input logic             pm_strobe,
   input logic             inc_vld,
   input logic [3:0]       inc_amt,
   input logic [CNT_W-1:0] run_count,
   input logic [CNT_W-1:0] hold_count
);
   localparam logic [CNT_W-1:0] MAXV = '1;
   logic [CNT_W:0] sum;
   assign sum = {1'b0, run_count} + {{(CNT_W-3){1'b0}}, inc_amt};

   assert_bit_limit_R3: assert property (@(posedge clk) disable iff (!rst_n)
      inc_vld |-> inc_amt <= 4'd8);

   assert_block_limit_R4: assert property (@(posedge clk) disable iff (!rst_n)
      inc_vld && $past(cfg_block_mode) |-> inc_amt <= 4'd1);

   assert_hold_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !pm_strobe |=> $stable(hold_count));

   assert_hold_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
      pm_strobe |=> hold_count == $past(run_count));

   assert_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
      pm_strobe |=> run_count == ($past(inc_vld) ? CNT_W'($past(inc_amt)) : '0));

   assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_saturate && !pm_strobe && inc_vld && sum[CNT_W] |=> run_count == MAXV);

   assert_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_saturate && !pm_strobe && inc_vld && sum[CNT_W]
      |=> run_count == $past(sum[CNT_W-1:0]));
endmodule

bind line_bip8_counter line_bip8_checker #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_block_mode(cfg_block_mode),
   .cfg_saturate(cfg_saturate), .pm_strobe(pm_strobe), .inc_vld(inc_vld),
   .inc_amt(inc_amt), .run_count(run_count), .hold_count(hold_count)
);

// File: tb/tb_line_bip8_counter.sv
module tb_line_bip8_counter;
   localparam int W = 6;   // small counter so overflow is reachable

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cfg_block_mode = 1'b0;
   logic         cfg_saturate = 1'b0;
   logic         in_valid = 1'b0;
   logic         in_sof = 1'b0;
   logic         in_lof = 1'b0;
   logic [3:0]   in_row = '0;
   logic [6:0]   in_col = '0;
   logic [7:0]   in_data = '0;
   logic         pm_strobe = 1'b0;
   logic [W-1:0] hold_count;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;
   logic [7:0] prev_par = 8'h00;
   int seed = 1;

   always #10 clk = ~clk;   // 50 MHz

   line_bip8_counter #(.CNT_W(W)) dut (
      .clk(clk), .rst_n(rst_n), .cfg_block_mode(cfg_block_mode),
      .cfg_saturate(cfg_saturate), .in_valid(in_valid), .in_sof(in_sof),
      .in_lof(in_lof), .in_row(in_row), .in_col(in_col), .in_data(in_data),
      .pm_strobe(pm_strobe), .hold_count(hold_count)
   );

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: got %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int ones(input logic [7:0] v);
      int n = 0;
      for (int i = 0; i < 8; i++) n += int'(v[i]);
      return n;
   endfunction

   // One frame; the check byte carries last frame's parity xor mask
   task automatic send_frame(input logic [7:0] mask, input bit strobe_after_chk);
      logic [7:0] par = 8'h00;
      logic [7:0] b;
      for (int r = 1; r <= 9; r++) begin
         for (int c = 1; c <= 90; c++) begin
            @(negedge clk);
            b = 8'((seed * 37) + (r * 11) + (c * 3) + (r * c));
            if (r == 5 && c == 1) b = prev_par ^ mask;
            if (!(r <= 3 && c <= 3)) par = par ^ b;
            in_valid  = 1'b1;
            in_sof    = (r == 1 && c == 1);
            in_row    = 4'(r);
            in_col    = 7'(c);
            in_data   = b;
            pm_strobe = strobe_after_chk && r == 5 && c == 2;
         end
      end
      @(negedge clk);
      in_valid  = 1'b0;
      in_sof    = 1'b0;
      pm_strobe = 1'b0;
      prev_par  = par;
      seed++;
   endtask

   task automatic strobe(output int val);
      @(negedge clk);
      pm_strobe = 1'b1;
      @(negedge clk);
      pm_strobe = 1'b0;
      val = int'(hold_count);
   endtask

   task automatic t_reset();
      int v;
      check("R10 hold after reset", int'(hold_count), 0);
      strobe(v);
      check("R10 count after reset", v, 0);
   endtask

   task automatic t_first_frame();
      int v;
      send_frame(8'hFF, 1'b0);   // nothing before it: must not compare
      strobe(v);
      check("R9 first frame after reset", v, 0);
   endtask

   task automatic t_bits();
      int v;
      cfg_block_mode = 1'b0;
      send_frame(8'h00, 1'b0);
      strobe(v);
      check("R1 clean frame, overhead excluded", v, 0);
      send_frame(8'h01, 1'b0);
      send_frame(8'hA5, 1'b0);
      strobe(v);
      check("R2 R3 bit count", v, 1 + ones(8'hA5));
   endtask

   task automatic t_blocks();
      int v;
      cfg_block_mode = 1'b1;
      send_frame(8'hFF, 1'b0);
      send_frame(8'h00, 1'b0);
      send_frame(8'h12, 1'b0);
      strobe(v);
      check("R4 block count", v, 2);
      cfg_block_mode = 1'b0;
   endtask

   task automatic t_collide();
      int v;
      send_frame(8'h07, 1'b0);
      send_frame(8'h0F, 1'b1);   // strobe meets this frame's error amount
      check("R5 hold at collision", int'(hold_count), 3);
      send_frame(8'h00, 1'b0);
      check("R5 hold stable without strobe", int'(hold_count), 3);
      strobe(v);
      check("R6 colliding errors kept", v, 4);
   endtask

   task automatic t_saturate();
      int v;
      cfg_saturate = 1'b1;
      for (int k = 0; k < 9; k++) send_frame(8'hFF, 1'b0);
      strobe(v);
      check("R7 saturate", v, 63);
      strobe(v);
      check("R6 cleared after strobe", v, 0);
   endtask

   task automatic t_wrap();
      int v;
      cfg_saturate = 1'b0;
      for (int k = 0; k < 9; k++) send_frame(8'hFF, 1'b0);
      strobe(v);
      check("R8 wrap", v, 72 % 64);
   endtask

   task automatic t_lof();
      int v;
      @(negedge clk);
      in_lof = 1'b1;
      repeat (5) @(negedge clk);
      in_lof = 1'b0;
      send_frame(8'hFF, 1'b0);
      strobe(v);
      check("R9 first frame after loss of frame", v, 0);
      send_frame(8'h03, 1'b0);
      strobe(v);
      check("R9 second frame after loss of frame", v, 2);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_first_frame();
      t_bits();
      t_blocks();
      t_collide();
      t_saturate();
      t_wrap();
      t_lof();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
   end
endmodule